// File: doc/BRIEF.md
# Addressing-Byte Effective Address Decoder

This block turns the addressing byte that follows an opcode in a 16-bit segmented processor into a memory location or a register number. The byte arrives on a serial byte stream, one byte per cycle while `byte_valid` is high. Any displacement bytes follow it on the same stream. The block also reads the live base and index registers (BX, BP, SI, DI) and the four segment registers. It produces the 16-bit offset, the chosen segment code and the 20-bit physical address. For a register operand it reports the register number instead. In every case it reports the 3-bit middle field, which is either the second register or an opcode extension.

The addressing byte splits into three fields. The top two bits select the mode (`00` no displacement, `01` 8-bit displacement, `10` 16-bit displacement, `11` register). The middle three bits are the column field. The low three bits select the base/index combination.

A one-cycle pulse on `ovr_valid` latches a segment override. The override applies only to the next decode that completes, including a register decode, and is then cleared.

The collector is a three-state machine:
- ST_IDLE waits for an addressing byte.
  - A register-mode byte, or a mode-`00` byte whose low field is not 6, completes in place (IDLE→IDLE).
  - Mode `01`, mode `10`, or the mode-`00`/low-field-6 direct case moves to ST_DISP_LO (IDLE→DISP_LO).
- ST_DISP_LO takes the first displacement byte.
  - An 8-bit displacement completes there (DISP_LO→IDLE).
  - A 16-bit displacement moves on (DISP_LO→DISP_HI).
- ST_DISP_HI takes the high byte and completes (DISP_HI→IDLE).

Cycles with `byte_valid` low leave every state unchanged.

Top module: `ea_decoder`

## Requirements
- R1: After reset, `done`, `busy`, `is_reg`, `reg_num`, `col_field`, `offset`, `seg_sel` and `phys_addr` are all zero.
- R2: Mode `11` (byte bits 7:6): `is_reg`=1 and `reg_num` equals byte bits 2:0. `offset`, `seg_sel` and `phys_addr` read zero. No displacement is taken.
- R3: Mode `00` with a low field other than 6 takes no displacement. The offset for low field 0..7 is BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, (6 excluded), BX.
- R4: Mode `00` with low field 6 is a direct address. It takes two displacement bytes, low byte first, and the offset is that 16-bit value with no register added.
- R5: Mode `01` takes one displacement byte. It is sign-extended and added to the base/index sum, where low field 6 means BP.
- R6: Mode `10` takes two displacement bytes, low byte first, added unsigned to the base/index sum.
- R7: Without an override, `seg_sel` is 2 (SS) when the address includes BP and 3 (DS) otherwise. The direct case counts as not including BP. The segment codes are 0=ES, 1=CS, 2=SS, 3=DS.
- R8: The offset wraps modulo 2^16. `phys_addr` = (segment value × 16 + offset) modulo 2^20.
- R9: An `ovr_valid` pulse with code `ovr_seg` replaces the default segment for the next completed decode only. The decode after that uses the default again.
- R10: `done` is high for the one cycle after the edge that accepts the final byte of a decode. That byte is the addressing byte itself when no displacement follows. `busy` is high while displacement bytes are pending, and idle cycles in between do not disturb the decode.
- R11: `col_field` equals byte bits 5:3 for both memory and register decodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Stream byte present this cycle |
| byte_data | input | 8 | Addressing or displacement byte |
| ovr_valid | input | 1 | Latch a one-shot segment override |
| ovr_seg | input | 2 | Override segment code (0=ES,1=CS,2=SS,3=DS) |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base register BP |
| reg_si | input | 16 | Index register SI |
| reg_di | input | 16 | Index register DI |
| seg_es | input | 16 | Segment register ES |
| seg_cs | input | 16 | Segment register CS |
| seg_ss | input | 16 | Segment register SS |
| seg_ds | input | 16 | Segment register DS |
| busy | output | 1 | Displacement bytes still pending |
| done | output | 1 | Decode result valid (one-cycle pulse) |
| is_reg | output | 1 | Result is a register operand |
| reg_num | output | 3 | Register number for register operands |
| col_field | output | 3 | Middle field of the addressing byte |
| offset | output | 16 | Effective offset |
| seg_sel | output | 2 | Segment code used |
| phys_addr | output | 20 | Physical address |

## Verification
Every result (`done`, `offset`, `seg_sel`, `phys_addr`, `is_reg`, `reg_num`, `col_field`) is registered once. It is therefore due in the cycle after the rising edge that accepts the final byte of the decode. `busy` rises in the cycle after the addressing byte of a displacement-bearing mode is accepted. The bench drives each byte on a falling edge, so exactly one rising edge consumes it. It then samples on the next falling edge, which lies inside the single cycle where `done` is high. The gap test inserts idle cycles between displacement bytes and checks that `busy` stays high and `done` stays low until the last byte has been counted.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DISP_LO = 2'd1,
        ST_DISP_HI = 2'd2
    } ea_state_t;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_DISP8  = 2'b01;
    localparam logic [1:0] MODE_DISP16 = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [2:0] RM_DIRECT   = 3'd6;

    localparam logic [1:0] SEG_ES = 2'd0;
    localparam logic [1:0] SEG_CS = 2'd1;
    localparam logic [1:0] SEG_SS = 2'd2;
    localparam logic [1:0] SEG_DS = 2'd3;
endpackage

// File: rtl/ea_collect.sv
module ea_collect
    import ea_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_valid,
    input  logic [BYTE_W-1:0]   byte_data,
    output logic                busy,
    output logic                fin,
    output logic [BYTE_W-1:0]   fin_modrm,
    output logic [2*BYTE_W-1:0] fin_disp
);
    ea_state_t         state_q, state_d;
    logic [BYTE_W-1:0] modrm_q;
    logic [BYTE_W-1:0] lo_q;
    logic [1:0]        in_mode;
    logic [2:0]        in_rm;

    assign in_mode = byte_data[7:6];
    assign in_rm   = byte_data[2:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modrm_q <= '0;
            lo_q    <= '0;
        end else if (byte_valid) begin
            if (state_q == ST_IDLE)    modrm_q <= byte_data;
            if (state_q == ST_DISP_LO) lo_q    <= byte_data;
        end
    end

    always_comb begin
        state_d   = state_q;
        fin       = 1'b0;
        fin_modrm = modrm_q;
        fin_disp  = '0;
        unique case (state_q)
            ST_IDLE: begin
                fin_modrm = byte_data;
                if (byte_valid) begin
                    if (in_mode == MODE_REG ||
                        (in_mode == MODE_NODISP && in_rm != RM_DIRECT))
                        fin = 1'b1;
                    else
                        state_d = ST_DISP_LO;
                end
            end
            ST_DISP_LO: begin
                fin_disp = {{BYTE_W{byte_data[BYTE_W-1]}}, byte_data};
                if (byte_valid) begin
                    if (modrm_q[7:6] == MODE_DISP8) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_DISP_HI;
                    end
                end
            end
            ST_DISP_HI: begin
                fin_disp = {byte_data, lo_q};
                if (byte_valid) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/ea_offset.sv
module ea_offset
    import ea_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [7:0]       modrm,
    input  logic [OFS_W-1:0] disp,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    output logic [OFS_W-1:0] ofs,
    output logic             bp_based
);
    logic [OFS_W-1:0] base_sum;
    logic [1:0]       mode;
    logic [2:0]       rm;

    assign mode = modrm[7:6];
    assign rm   = modrm[2:0];

    always_comb begin
        bp_based = 1'b0;
        unique case (rm)
            3'd0: base_sum = bx + si;
            3'd1: base_sum = bx + di;
            3'd2: begin base_sum = bp + si; bp_based = 1'b1; end
            3'd3: begin base_sum = bp + di; bp_based = 1'b1; end
            3'd4: base_sum = si;
            3'd5: base_sum = di;
            3'd6: begin
                if (mode == MODE_NODISP) begin
                    base_sum = '0;
                end else begin
                    base_sum = bp;
                    bp_based = 1'b1;
                end
            end
            default: base_sum = bx;
        endcase
        ofs = base_sum + disp;
    end
endmodule

// File: rtl/ea_segsel.sv
module ea_segsel
    import ea_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
    input  logic              bp_based,
    input  logic              ovr_pend,
    input  logic [1:0]        ovr_code,
    input  logic [OFS_W-1:0]  es,
    input  logic [OFS_W-1:0]  cs,
    input  logic [OFS_W-1:0]  ss,
    input  logic [OFS_W-1:0]  ds,
    input  logic [OFS_W-1:0]  ofs,
    output logic [1:0]        seg_code,
    output logic [PHYS_W-1:0] phys
);
    logic [OFS_W-1:0] seg_val;

    always_comb begin
        if (ovr_pend)      seg_code = ovr_code;
        else if (bp_based) seg_code = SEG_SS;
        else               seg_code = SEG_DS;
        unique case (seg_code)
            SEG_ES:  seg_val = es;
            SEG_CS:  seg_val = cs;
            SEG_SS:  seg_val = ss;
            default: seg_val = ds;
        endcase
        phys = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs};
    end
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
    import ea_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_seg,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    input  logic [OFS_W-1:0]  seg_es,
    input  logic [OFS_W-1:0]  seg_cs,
    input  logic [OFS_W-1:0]  seg_ss,
    input  logic [OFS_W-1:0]  seg_ds,
    output logic              busy,
    output logic              done,
    output logic              is_reg,
    output logic [2:0]        reg_num,
    output logic [2:0]        col_field,
    output logic [OFS_W-1:0]  offset,
    output logic [1:0]        seg_sel,
    output logic [PHYS_W-1:0] phys_addr
);
    logic              fin;
    logic [7:0]        fin_modrm;
    logic [OFS_W-1:0]  fin_disp;
    logic [OFS_W-1:0]  calc_ofs;
    logic              calc_bp;
    logic [1:0]        calc_seg;
    logic [PHYS_W-1:0] calc_phys;
    logic              ovr_pend_q;
    logic [1:0]        ovr_code_q;
    logic              fin_is_reg;

    ea_collect #(.BYTE_W(8)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .busy       (busy),
        .fin        (fin),
        .fin_modrm  (fin_modrm),
        .fin_disp   (fin_disp)
    );

    ea_offset #(.OFS_W(OFS_W)) u_offset (
        .modrm    (fin_modrm),
        .disp     (fin_disp),
        .bx       (reg_bx),
        .bp       (reg_bp),
        .si       (reg_si),
        .di       (reg_di),
        .ofs      (calc_ofs),
        .bp_based (calc_bp)
    );

    ea_segsel #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_segsel (
        .bp_based (calc_bp),
        .ovr_pend (ovr_pend_q),
        .ovr_code (ovr_code_q),
        .es       (seg_es),
        .cs       (seg_cs),
        .ss       (seg_ss),
        .ds       (seg_ds),
        .ofs      (calc_ofs),
        .seg_code (calc_seg),
        .phys     (calc_phys)
    );

    assign fin_is_reg = (fin_modrm[7:6] == MODE_REG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pend_q <= 1'b0;
            ovr_code_q <= SEG_ES;
        end else if (ovr_valid) begin
            ovr_pend_q <= 1'b1;
            ovr_code_q <= ovr_seg;
        end else if (fin) begin
            ovr_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            is_reg    <= 1'b0;
            reg_num   <= '0;
            col_field <= '0;
            offset    <= '0;
            seg_sel   <= '0;
            phys_addr <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                is_reg    <= fin_is_reg;
                col_field <= fin_modrm[5:3];
                reg_num   <= fin_is_reg ? fin_modrm[2:0] : 3'd0;
                offset    <= fin_is_reg ? '0 : calc_ofs;
                seg_sel   <= fin_is_reg ? 2'd0 : calc_seg;
                phys_addr <= fin_is_reg ? '0 : calc_phys;
            end
        end
    end
endmodule

// File: rtl/ea_decoder_chk.sv
module ea_decoder_chk #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              busy,
    input logic              done,
    input logic              is_reg,
    input logic [OFS_W-1:0]  offset,
    input logic [1:0]        seg_sel,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [OFS_W-1:0]  seg_es,
    input logic [OFS_W-1:0]  seg_cs,
    input logic [OFS_W-1:0]  seg_ss,
    input logic [OFS_W-1:0]  seg_ds
);
    logic [OFS_W-1:0]  es_q, cs_q, ss_q, ds_q, sel_val;
    logic [PHYS_W-1:0] exp_phys;

    always_ff @(posedge clk) begin
        es_q <= seg_es;
        cs_q <= seg_cs;
        ss_q <= seg_ss;
        ds_q <= seg_ds;
    end

    always_comb begin
        case (seg_sel)
            2'd0:    sel_val = es_q;
            2'd1:    sel_val = cs_q;
            2'd2:    sel_val = ss_q;
            default: sel_val = ds_q;
        endcase
        exp_phys = {sel_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};
    end

    assert_done_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_valid));
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_from_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(byte_valid));
    assert_reg_no_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> (offset == '0 && phys_addr == '0));
    assert_phys_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_reg && $past(rst_n)) |-> (phys_addr == exp_phys));
endmodule

bind ea_decoder ea_decoder_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .busy       (busy),
    .done       (done),
    .is_reg     (is_reg),
    .offset     (offset),
    .seg_sel    (seg_sel),
    .phys_addr  (phys_addr),
    .seg_es     (seg_es),
    .seg_cs     (seg_cs),
    .seg_ss     (seg_ss),
    .seg_ds     (seg_ds)
);

// File: tb/test_ea_decoder.sv
module test_ea_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] reg_bx = 16'h1000, reg_bp = 16'h2000, reg_si = 16'h0030, reg_di = 16'h0004;
    logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
    logic        busy, done, is_reg;
    logic [2:0]  reg_num, col_field;
    logic [15:0] offset;
    logic [1:0]  seg_sel;
    logic [19:0] phys_addr;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ea_decoder i_ea_decoder (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .busy(busy), .done(done), .is_reg(is_reg), .reg_num(reg_num),
        .col_field(col_field), .offset(offset), .seg_sel(seg_sel), .phys_addr(phys_addr)
    );

    localparam int NV = 13;
    localparam logic [7:0]  V_MODRM [NV] = '{8'h00, 8'h0B, 8'h14, 8'h3F, 8'h06, 8'h46, 8'h6F,
                                             8'h42, 8'h85, 8'h81, 8'hC5, 8'hFA, 8'h45};
    localparam int          V_NB    [NV] = '{1, 1, 1, 1, 3, 2, 2, 2, 3, 3, 1, 1, 2};
    localparam logic [7:0]  V_LO    [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h34, 8'h10, 8'h11,
                                             8'hF0, 8'hFF, 8'h34, 8'h00, 8'h00, 8'h80};
    localparam logic [7:0]  V_HI    [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00,
                                             8'h00, 8'hFF, 8'h12, 8'h00, 8'h00, 8'h00};
    localparam logic [15:0] V_OFS   [NV] = '{16'h1030, 16'h2004, 16'h0030, 16'h1000, 16'h1234,
                                             16'h2010, 16'h1011, 16'h2020, 16'h0003, 16'h2238,
                                             16'h0000, 16'h0000, 16'hFF84};
    localparam logic [1:0]  V_SEG   [NV] = '{2'd3, 2'd2, 2'd3, 2'd3, 2'd3, 2'd2, 2'd3,
                                             2'd2, 2'd3, 2'd3, 2'd0, 2'd0, 2'd3};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
    endtask

    task automatic finish_bytes();
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    function automatic logic [19:0] phys_of(input logic [1:0] s, input logic [15:0] o);
        logic [15:0] sv;
        case (s)
            2'd0: sv = seg_es;
            2'd1: sv = seg_cs;
            2'd2: sv = seg_ss;
            default: sv = seg_ds;
        endcase
        return {sv, 4'h0} + {4'h0, o};
    endfunction

    initial begin
        #(20 * 5000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && busy == 0 && offset == 0 && phys_addr == 0 && is_reg == 0 &&
            seg_sel == 0 && col_field == 0 && reg_num == 0, "R1 reset state",
            {phys_addr, offset[11:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            string tg;
            m = V_MODRM[i][7:6];
            if (m == 2'b11) tg = "R2";
            else if (m == 2'b01) tg = "R5";
            else if (m == 2'b10) tg = "R6";
            else if (V_MODRM[i][2:0] == 3'd6) tg = "R4";
            else tg = "R3";
            send(V_MODRM[i]);
            if (V_NB[i] > 1) send(V_LO[i]);
            if (V_NB[i] > 2) send(V_HI[i]);
            finish_bytes();
            chk(done === 1'b1, {tg, " R10 done due"}, done, 1);
            chk(offset === V_OFS[i], {tg, " offset"}, offset, V_OFS[i]);
            chk(col_field === V_MODRM[i][5:3], "R11 col field", col_field, V_MODRM[i][5:3]);
            if (m == 2'b11) begin
                chk(is_reg === 1'b1 && reg_num === V_MODRM[i][2:0], "R2 register number",
                    {is_reg, reg_num}, {1'b1, V_MODRM[i][2:0]});
                chk(phys_addr === 20'h0, "R2 phys zero", phys_addr, 0);
            end else begin
                chk(is_reg === 1'b0, "R2 memory is_reg", is_reg, 0);
                chk(seg_sel === V_SEG[i], "R7 default segment", seg_sel, V_SEG[i]);
                chk(phys_addr === phys_of(V_SEG[i], V_OFS[i]), "R8 physical",
                    phys_addr, phys_of(V_SEG[i], V_OFS[i]));
            end
            @(negedge clk);
            chk(done === 1'b0, "R10 single pulse", done, 0);
        end

        // R10: gaps between displacement bytes, busy held
        send(8'h86);
        finish_bytes();
        chk(busy === 1'b1 && done === 1'b0, "R10 busy after addr byte", {busy, done}, 2'b10);
        repeat (2) @(negedge clk);
        send(8'h02);
        finish_bytes();
        chk(busy === 1'b1 && done === 1'b0, "R10 busy mid disp", {busy, done}, 2'b10);
        @(negedge clk);
        send(8'h01);
        finish_bytes();
        chk(done === 1'b1 && busy === 1'b0 && offset === 16'h2102 && seg_sel === 2'd2,
            "R6 gapped disp", offset, 16'h2102);

        // R9: override ES applies once
        @(negedge clk);
        ovr_valid = 1'b1; ovr_seg = 2'd0;
        @(negedge clk);
        ovr_valid = 1'b0;
        send(8'h07);
        finish_bytes();
        chk(seg_sel === 2'd0 && phys_addr === 20'h11000, "R9 override used", phys_addr, 20'h11000);
        send(8'h07);
        finish_bytes();
        chk(seg_sel === 2'd3 && phys_addr === 20'h41000, "R9 override cleared", phys_addr, 20'h41000);

        // R9: override CS consumed by a register decode
        @(negedge clk);
        ovr_valid = 1'b1; ovr_seg = 2'd1;
        @(negedge clk);
        ovr_valid = 1'b0;
        send(8'hC0);
        finish_bytes();
        send(8'h46);
        send(8'h00);
        finish_bytes();
        chk(seg_sel === 2'd2 && offset === 16'h2000, "R9 consumed by register decode",
            seg_sel, 2'd2);

        // R8: physical wrap
        seg_ds = 16'hFFFF;
        send(8'h06);
        send(8'hF0);
        send(8'hFF);
        finish_bytes();
        chk(offset === 16'hFFF0 && phys_addr === 20'h0FFE0, "R8 physical wrap",
            phys_addr, 20'h0FFE0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule